// File: doc/BRIEF.md
# Interrupt Status, Mask and Inject Register Bank

This block holds the interrupt registers of one peripheral. It has a sticky pending register, a mask register and a write-only inject register. A pending bit is set by a hardware event input or by an inject write. Software clears a pending bit by writing a one to it. Each interrupt pin is the registered AND of its pending bit and its mask bit. The peripheral drives the event inputs, and the interrupt pins go to the interrupt controller.

Software reaches the registers through a plain synchronous register port. An access is one cycle wide: an enable, a write strobe, an address and write data. The response comes in the next cycle as read data and an error flag. All three registers use bits `[NUM_IRQ-1:0]` of the data word. Reset is asynchronous and active low, and its release is synchronised inside the block.

Top module: `irq_csr_bank`

## Requirements
- R1: A high event input sets its pending bit whatever the mask bit is. The bit stays set after the event goes low.
- R2: A write to the inject register (byte address 0x08) ORs the written bits into the pending register, and bits already set stay set. A read of the inject register returns zero.
- R3: A write to the pending register (byte address 0x00) clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R4: The mask register (byte address 0x04) is read/write. A write replaces all of its bits and a read returns the value last written.
- R5: Interrupt pin i equals pending bit i AND mask bit i, and it changes one clock after the pending or mask register changes.
- R6: When an event or an inject write sets a bit in the same cycle as a clearing write to that bit, the bit ends up set.
- R7: While reset is low, every interrupt pin is zero. After reset, the pending and mask registers read zero.
- R8: Read data bits at and above `NUM_IRQ` are always zero.
- R9: An access to any other address, including one that is not word aligned, returns zero data with the error flag high for one cycle. A write to such an address changes no register.
- R10: The response to an access appears in the cycle after the access, and a write returns zero data.
- R11: Once every pending bit is cleared, every interrupt pin reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_i | input | NUM_IRQ | Hardware event inputs, level sampled each cycle |
| bus_en_i | input | 1 | Register access valid this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, one cycle after the access |
| bus_err_o | output | 1 | Unmapped access flag, one cycle after the access |
| irq_o | output | NUM_IRQ | Registered interrupt pins |

## Verification
An event on an unmasked bit and an event on a masked bit both set pending, but only the unmasked one drives a pin. This separates the pending path from the mask path. Inject writes are applied on top of bits already pending, and clear patterns mix ones and zeros, so an overwrite is told apart from an OR and a full clear from a per-bit clear. An event collides with a clear of the same bit to show which of the two wins. Pins are sampled in the cycle right after a change and again one cycle later to pin down the latency. Unmapped and misaligned accesses are followed by reads of the real registers to show that nothing changed.

// File: rtl/irq_csr_pkg.sv
`timescale 1ns/1ps
package irq_csr_pkg;
  localparam int unsigned OFS_PEND   = 32'h0;
  localparam int unsigned OFS_MASK   = 32'h4;
  localparam int unsigned OFS_INJECT = 32'h8;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_PEND,
    SEL_MASK,
    SEL_INJECT
  } csr_sel_e;
endpackage

// File: rtl/irq_rst_sync.sv
`timescale 1ns/1ps
module irq_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/irq_csr_decode.sv
`timescale 1ns/1ps
module irq_csr_decode
  import irq_csr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output csr_sel_e          sel_o
);
  always_comb begin
    if (addr_i == ADDR_W'(OFS_PEND))        sel_o = SEL_PEND;
    else if (addr_i == ADDR_W'(OFS_MASK))   sel_o = SEL_MASK;
    else if (addr_i == ADDR_W'(OFS_INJECT)) sel_o = SEL_INJECT;
    else                                    sel_o = SEL_NONE;
  end
endmodule

// File: rtl/irq_sticky_bits.sv
`timescale 1ns/1ps
module irq_sticky_bits #(
  parameter int unsigned NUM_IRQ = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] set_i,
  input  logic [NUM_IRQ-1:0] clr_i,
  output logic [NUM_IRQ-1:0] state_o
);
  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_bit
    logic bit_q, bit_d, bit_en;

    // set has priority over clear
    always_comb begin
      bit_en = set_i[g] | clr_i[g];
      bit_d  = set_i[g];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     bit_q <= 1'b0;
      else if (bit_en) bit_q <= bit_d;
    end

    assign state_o[g] = bit_q;
  end
endmodule

// File: rtl/irq_pin_reg.sv
`timescale 1ns/1ps
module irq_pin_reg #(
  parameter int unsigned NUM_IRQ = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rst_sync_ni,
  input  logic [NUM_IRQ-1:0] state_i,
  input  logic [NUM_IRQ-1:0] mask_i,
  output logic [NUM_IRQ-1:0] irq_o
);
  logic [NUM_IRQ-1:0] pin_d, pin_q;

  always_comb begin
    pin_d = rst_sync_ni ? (state_i & mask_i) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= '0;
    else         pin_q <= pin_d;
  end

  assign irq_o = pin_q;
endmodule

// File: rtl/irq_csr_bank.sv
`timescale 1ns/1ps
module irq_csr_bank
  import irq_csr_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] evt_i,
  input  logic               bus_en_i,
  input  logic               bus_we_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  output logic               bus_err_o,
  output logic [NUM_IRQ-1:0] irq_o
);
  logic rst_sync_n;
  csr_sel_e sel;
  logic wr_pend, wr_mask, wr_inject, rd_en;
  logic [NUM_IRQ-1:0] wbits;
  logic [NUM_IRQ-1:0] pend_q, pend_set, pend_clr;
  logic [NUM_IRQ-1:0] mask_q, mask_d;
  logic               mask_en;
  logic [DATA_W-1:0]  rdata_d, rdata_q;
  logic               err_d, err_q;

  irq_rst_sync u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  irq_csr_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr_i (bus_addr_i),
    .sel_o  (sel)
  );

  always_comb begin
    wbits     = bus_wdata_i[NUM_IRQ-1:0];
    wr_pend   = bus_en_i &  bus_we_i & (sel == SEL_PEND);
    wr_mask   = bus_en_i &  bus_we_i & (sel == SEL_MASK);
    wr_inject = bus_en_i &  bus_we_i & (sel == SEL_INJECT);
    rd_en     = bus_en_i & ~bus_we_i;
    pend_set  = evt_i | (wr_inject ? wbits : '0);
    pend_clr  = wr_pend ? wbits : '0;
  end

  irq_sticky_bits #(.NUM_IRQ(NUM_IRQ)) u_pend (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .set_i   (pend_set),
    .clr_i   (pend_clr),
    .state_o (pend_q)
  );

  // mask register
  always_comb begin
    mask_en = wr_mask;
    mask_d  = wbits;
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n)  mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  irq_pin_reg #(.NUM_IRQ(NUM_IRQ)) u_pins (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_ni (rst_sync_n),
    .state_i     (pend_q),
    .mask_i      (mask_q),
    .irq_o       (irq_o)
  );

  // response path
  always_comb begin
    rdata_d = '0;
    if (rd_en) begin
      case (sel)
        SEL_PEND: rdata_d = DATA_W'(pend_q);
        SEL_MASK: rdata_d = DATA_W'(mask_q);
        default:  rdata_d = '0;
      endcase
    end
    err_d = bus_en_i & (sel == SEL_NONE);
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      rdata_q <= rdata_d;
      err_q   <= err_d;
    end
  end

  assign bus_rdata_o = rdata_q;
  assign bus_err_o   = err_q;
endmodule

// File: rtl/irq_csr_bank_chk.sv
`timescale 1ns/1ps
module irq_csr_bank_chk
  import irq_csr_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               rst_sync_n,
  input logic [NUM_IRQ-1:0] evt_i,
  input logic               bus_en_i,
  input logic               bus_we_i,
  input logic [ADDR_W-1:0]  bus_addr_i,
  input logic [DATA_W-1:0]  bus_wdata_i,
  input logic [DATA_W-1:0]  bus_rdata_o,
  input logic               bus_err_o,
  input logic [NUM_IRQ-1:0] irq_o,
  input logic [NUM_IRQ-1:0] pend_q,
  input logic [NUM_IRQ-1:0] mask_q
);
  localparam logic [DATA_W-1:0] USED = DATA_W'({NUM_IRQ{1'b1}});

  a_r1_event_sets: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (|evt_i) |=> ((pend_q & $past(evt_i)) == $past(evt_i)));

  a_r3_w1c: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (bus_en_i && bus_we_i && bus_addr_i == ADDR_W'(OFS_PEND) && evt_i == '0)
    |=> (pend_q == ($past(pend_q) & ~$past(bus_wdata_i[NUM_IRQ-1:0]))));

  a_r5_pin_latency: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    irq_o == $past(pend_q & mask_q));

  a_r7_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> (irq_o == '0 && pend_q == '0));

  a_r8_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (bus_rdata_o & ~USED) == '0);

  a_r9_err_zero_data: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    bus_err_o |-> (bus_rdata_o == '0));

  a_r10_err_follows_access: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    bus_err_o |-> $past(bus_en_i));
endmodule

bind irq_csr_bank irq_csr_bank_chk #(
  .NUM_IRQ(NUM_IRQ), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rst_sync_n  (rst_sync_n),
  .evt_i       (evt_i),
  .bus_en_i    (bus_en_i),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .bus_err_o   (bus_err_o),
  .irq_o       (irq_o),
  .pend_q      (pend_q),
  .mask_q      (mask_q)
);

// File: tb/irq_csr_bank_tb.sv
`timescale 1ns/1ps
module irq_csr_bank_tb;
  localparam int N  = 8;
  localparam int DW = 32;
  localparam int AW = 8;

  typedef struct {
    logic [DW-1:0] data;
    logic          err;
    string         tag;
  } resp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b1;
  logic [N-1:0]  evt = '0;
  logic          bus_en = 1'b0;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          bus_err;
  logic [N-1:0]  irq;

  int checks = 0;
  int errors = 0;
  resp_t exp_q[$];
  logic [N-1:0] m_pend = '0;
  logic [N-1:0] m_mask = '0;

  always #2 clk = ~clk;

  irq_csr_bank #(.NUM_IRQ(N), .DATA_W(DW), .ADDR_W(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt),
    .bus_en_i(bus_en), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .bus_err_o(bus_err),
    .irq_o(irq)
  );

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // driver: one access, expected response pushed to the scoreboard
  task automatic bus(input bit we, input logic [AW-1:0] addr, input logic [DW-1:0] wd,
                     input logic [N-1:0] ev, input string tag);
    resp_t r;
    bit mapped;
    @(negedge clk);
    bus_en = 1'b1; bus_we = we; bus_addr = addr; bus_wdata = wd; evt = ev;
    mapped = (addr == 8'h00) || (addr == 8'h04) || (addr == 8'h08);
    r.tag = tag; r.err = !mapped; r.data = '0;
    if (mapped && !we) begin
      if (addr == 8'h00) r.data = DW'(m_pend);
      else if (addr == 8'h04) r.data = DW'(m_mask);
    end
    exp_q.push_back(r);
    m_pend = m_pend | ev;
    if (mapped && we) begin
      if (addr == 8'h00) m_pend = (m_pend & ~wd[N-1:0]) | ev;
      else if (addr == 8'h04) m_mask = wd[N-1:0];
      else m_pend = m_pend | wd[N-1:0];
    end
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0; evt = '0;
  endtask

  task automatic pulse_evt(input logic [N-1:0] ev, input int cycles);
    @(negedge clk);
    evt = ev;
    repeat (cycles) @(negedge clk);
    evt = '0;
    m_pend = m_pend | ev;
  endtask

  task automatic check_pins(input logic [N-1:0] exp, input string tag);
    @(negedge clk);
    check(irq === exp, tag, DW'(irq), DW'(exp));
  endtask

  // monitor: compare each response one cycle after its access (R10)
  initial begin
    forever begin
      bit pend;
      resp_t r;
      @(posedge clk);
      pend = bus_en;
      @(negedge clk);
      if (pend) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R10 unexpected response", bus_rdata, '0);
        end else begin
          r = exp_q.pop_front();
          check(bus_rdata === r.data, {r.tag, " R10 data"}, bus_rdata, r.data);
          check(bus_err === r.err, {r.tag, " R9 err"}, DW'(bus_err), DW'(r.err));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", '0, '0);
    finish_run();
  end

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(irq === '0, "R7 pins low in reset", DW'(irq), '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    bus(0, 8'h00, '0, '0, "R7 pend after reset");
    bus(0, 8'h04, '0, '0, "R7 mask after reset");
    // R4 + R8: wide write, only low bits kept
    bus(1, 8'h04, 32'hFFFF_FFA5, '0, "R4 mask write");
    bus(0, 8'h04, '0, '0, "R4 R8 mask readback");
    bus(1, 8'h04, 32'h0000_008F, '0, "R4 mask rewrite");
    bus(0, 8'h04, '0, '0, "R4 mask readback 2");
    // R1: masked event latches, pin stays low
    pulse_evt(8'h40, 3);
    bus(0, 8'h00, '0, '0, "R1 sticky pend");
    check_pins(8'h00, "R1 masked event no pin");
    // R2 + R5: inject and pin latency
    bus(1, 8'h08, 32'h31, '0, "R2 inject write");
    check(irq === 8'h00, "R5 pin not yet changed", DW'(irq), 32'h0);
    check_pins(8'h01, "R5 pin one clock later");
    bus(0, 8'h00, '0, '0, "R2 pend after inject");
    bus(0, 8'h08, '0, '0, "R2 inject reads zero");
    // R3: mixed one/zero clear
    bus(1, 8'h00, 32'h41, '0, "R3 w1c write");
    bus(0, 8'h00, '0, '0, "R3 pend after clear");
    check_pins(8'h00, "R5 pins after clear");
    bus(1, 8'h04, 32'hF0, '0, "R5 mask change");
    check_pins(8'h30, "R5 pins follow mask");
    // R6: set wins over same-cycle clear
    bus(1, 8'h00, 32'h10, 8'h10, "R6 collide write");
    bus(0, 8'h00, '0, '0, "R6 pend kept");
    bus(1, 8'h00, 32'h20, '0, "R3 clear one bit");
    bus(0, 8'h00, '0, '0, "R3 pend one left");
    // R9: unmapped and misaligned
    bus(0, 8'h0C, '0, '0, "R9 unmapped read");
    check_pins(8'h10, "R9 err idle cycle pins");
    check(bus_err === 1'b0, "R9 err one cycle only", DW'(bus_err), 32'h0);
    bus(1, 8'h03, 32'hFF, '0, "R9 misaligned write");
    bus(0, 8'h00, '0, '0, "R9 pend untouched");
    bus(0, 8'h04, '0, '0, "R9 mask untouched");
    // R11: clear everything
    bus(1, 8'h00, 32'hFF, '0, "R11 clear all");
    bus(0, 8'h00, '0, '0, "R11 pend zero");
    check_pins(8'h00, "R11 pins zero");
    // R7: reset mid-run
    bus(1, 8'h08, 32'hF0, '0, "R7 inject before reset");
    check_pins(8'hF0, "R7 pins before reset");
    rst_n = 1'b0;
    @(negedge clk);
    check(irq === '0, "R7 pins cleared by reset", DW'(irq), '0);
    m_pend = '0; m_mask = '0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    bus(0, 8'h00, '0, '0, "R7 pend after second reset");
    bus(0, 8'h04, '0, '0, "R7 mask after second reset");
    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "scoreboard drained", DW'(exp_q.size()), '0);
    finish_run();
  end
endmodule